// File: doc/BRIEF.md
# Strided Vector Load Address Sequencer

This block turns one vector load into a run of single-element memory reads. When `start` is accepted it captures the destination register index, the base register index, the vector length and the instruction's immediate. It also picks an element offset and a stride from a small table of offset entries. The table is searched for the base register index. The sequencer then walks the elements in ascending order. For each element it reads the per-element base value from the register file, forms the memory address, issues one read request and waits for the response. It then writes the returned word into the next destination register.

For element `i` the address is `(offset * i + r[base+i]) * stride`, computed in 32-bit arithmetic. With no table match the offset is 0 and the stride is 1, so each element reads from the address held in its base register. The register file and the memory sit outside the block. The read port is combinational. The memory uses a valid/ready request channel and a single-cycle response strobe. A one-cycle `done` pulse marks the end of the instruction.

Top module: `vload_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `done`, `mem_req_valid` and `rf_we` are all low.
- R2: An accepted start with vector length L gives exactly L writebacks in ascending element order. Element i writes register `(dst_reg + i) mod 2^REG_AW`.
- R3: When no offset entry holds `base_reg`, element i's address equals the value of register `(base_reg + i) mod 2^REG_AW`. The offset is 0 and the stride is 1.
- R4: Entry k sits at `ent_reg[k*REG_AW +: REG_AW]`, `ent_off[k*XLEN +: XLEN]` and `ent_mode[k]`. Entries are searched from index 0 upward, and the lowest-indexed entry whose register equals `base_reg` supplies the offset. Later matching entries have no effect.
- R5: If the selected entry's mode bit is 1, the stride is `imm_off`. If it is 0, the stride is 1.
- R6: Element i's request address is `(offset*i + r[base+i]) * stride`, taken modulo 2^32.
- R7: At most one memory request is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. No new request is raised until the previous response has been written back.
- R8: A vector length of 0 raises `done` in the cycle after the start is accepted, and no request is issued.
- R9: `start` is ignored while `busy` is high, including the `done` cycle. Inputs presented with such a start change nothing.
- R10: `done` is a single-cycle pulse in the cycle after the final writeback. `busy` is high from the cycle after the start until the `done` cycle, inclusive.
- R11: Each writeback carries the data of the response to that element's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a vector load (accepted only when idle) |
| dst_reg | input | REG_AW | Destination register index N |
| base_reg | input | REG_AW | Base register index M |
| imm_off | input | XLEN | Immediate load offset (stride in offset mode) |
| vec_len | input | VL_W | Element count configured for N |
| ent_reg | input | NUM_ENT*REG_AW | Register index of each offset entry |
| ent_off | input | NUM_ENT*XLEN | Offset amount of each entry |
| ent_mode | input | NUM_ENT | Stride-mode bit of each entry (1 = stride from immediate) |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | REG_AW | Register-file read index |
| rf_rdata | input | XLEN | Register-file read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | XLEN | Memory read address |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | XLEN | Memory response data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | REG_AW | Register-file write index |
| rf_wdata | output | XLEN | Register-file write data |

## Verification
The bench aims at the table search when both entries match the base register. A design that let the later entry win would use the wrong offset and stride on every element. It also drives a zero vector length, where a design that entered its element loop anyway would issue a request with a garbage address or miss the one-cycle `done`. Register indices that wrap past the top of the file, and addresses whose product overflows 32 bits, catch code that widens or saturates instead of wrapping. A start pulse with different operands during a running load exposes a design that restarts or mixes in the new operands. Ready backpressure and varying response latency expose requests that change while waiting, or a second request issued before the response has come back.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REQ,
      ST_WAIT,
      ST_WB,
      ST_DONE
   } vls_state_e;

endpackage

// File: rtl/vls_csr_match.sv
`timescale 1ns/1ps
// Priority search of the offset table: lowest index that names the key wins.
module vls_csr_match #(
   parameter int XLEN    = 32,
   parameter int REG_AW  = 5,
   parameter int NUM_ENT = 2
) (
   input  logic [REG_AW-1:0]         key,
   input  logic [XLEN-1:0]           imm,
   input  logic [NUM_ENT*REG_AW-1:0] ent_reg,
   input  logic [NUM_ENT*XLEN-1:0]   ent_off,
   input  logic [NUM_ENT-1:0]        ent_mode,
   output logic [XLEN-1:0]           off_sel,
   output logic [XLEN-1:0]           stride_sel
);

   logic [NUM_ENT-1:0] hit;

   generate
      for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
         assign hit[k] = (ent_reg[k*REG_AW +: REG_AW] == key);
      end
   endgenerate

   always_comb begin
      off_sel    = '0;
      stride_sel = XLEN'(1);
      for (int k = NUM_ENT - 1; k >= 0; k--) begin
         if (hit[k]) begin
            off_sel    = ent_off[k*XLEN +: XLEN];
            stride_sel = ent_mode[k] ? imm : XLEN'(1);
         end
      end
   end

endmodule

// File: rtl/vls_addr_calc.sv
`timescale 1ns/1ps
// Element address: (offset * index + base value) * stride, wrapping at XLEN bits.
module vls_addr_calc #(
   parameter int XLEN  = 32,
   parameter int IDX_W = 6
) (
   input  logic [XLEN-1:0]  off,
   input  logic [IDX_W-1:0] idx,
   input  logic [XLEN-1:0]  base_val,
   input  logic [XLEN-1:0]  stride,
   output logic [XLEN-1:0]  addr
);

   logic [XLEN-1:0] idx_x;
   logic [XLEN-1:0] scaled;
   logic [XLEN-1:0] summed;

   generate
      if (IDX_W >= XLEN) begin : g_trunc
         assign idx_x = idx[XLEN-1:0];
      end else begin : g_zext
         assign idx_x = {{(XLEN-IDX_W){1'b0}}, idx};
      end
   endgenerate

   assign scaled = off * idx_x;
   assign summed = scaled + base_val;
   assign addr   = summed * stride;

endmodule

// File: rtl/vls_ctrl.sv
`timescale 1ns/1ps
// Element sequencing FSM: one request in flight, ascending element order.
module vls_ctrl
   import vls_pkg::*;
#(
   parameter int VL_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VL_W-1:0] vec_len,
   input  logic            req_ready,
   input  logic            rsp_valid,
   output logic [VL_W-1:0] idx,
   output logic            load,
   output logic            cap_addr,
   output logic            cap_data,
   output logic            req_valid,
   output logic            wb_en,
   output logic            busy,
   output logic            done
);

   vls_state_e      st_q;
   logic [VL_W-1:0] idx_q;
   logic [VL_W-1:0] len_q;
   logic            last;

   assign last = ({1'b0, idx_q} + (VL_W+1)'(1)) == {1'b0, len_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         len_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  len_q <= vec_len;
                  idx_q <= '0;
                  st_q  <= (vec_len == '0) ? ST_DONE : ST_ADDR;
               end
            end
            ST_ADDR: st_q <= ST_REQ;
            ST_REQ:  if (req_ready) st_q <= ST_WAIT;
            ST_WAIT: if (rsp_valid) st_q <= ST_WB;
            ST_WB: begin
               if (last) begin
                  st_q <= ST_DONE;
               end else begin
                  idx_q <= idx_q + VL_W'(1);
                  st_q  <= ST_ADDR;
               end
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idx       = idx_q;
   assign load      = (st_q == ST_IDLE) && start;
   assign cap_addr  = (st_q == ST_ADDR);
   assign cap_data  = (st_q == ST_WAIT) && rsp_valid;
   assign req_valid = (st_q == ST_REQ);
   assign wb_en     = (st_q == ST_WB);
   assign busy      = (st_q != ST_IDLE);
   assign done      = (st_q == ST_DONE);

endmodule

// File: rtl/vload_seq.sv
`timescale 1ns/1ps
module vload_seq #(
   parameter int XLEN    = 32,
   parameter int REG_AW  = 5,
   parameter int VL_W    = 6,
   parameter int NUM_ENT = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [REG_AW-1:0]         dst_reg,
   input  logic [REG_AW-1:0]         base_reg,
   input  logic [XLEN-1:0]           imm_off,
   input  logic [VL_W-1:0]           vec_len,
   input  logic [NUM_ENT*REG_AW-1:0] ent_reg,
   input  logic [NUM_ENT*XLEN-1:0]   ent_off,
   input  logic [NUM_ENT-1:0]        ent_mode,
   output logic                      busy,
   output logic                      done,
   output logic [REG_AW-1:0]         rf_raddr,
   input  logic [XLEN-1:0]           rf_rdata,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   output logic [XLEN-1:0]           mem_req_addr,
   input  logic                      mem_rsp_valid,
   input  logic [XLEN-1:0]           mem_rsp_data,
   output logic                      rf_we,
   output logic [REG_AW-1:0]         rf_waddr,
   output logic [XLEN-1:0]           rf_wdata
);

   generate
      if (XLEN < 8)     begin : g_bad_xlen   $error("vload_seq: XLEN below 8");     end
      if (REG_AW < 1)   begin : g_bad_regaw  $error("vload_seq: REG_AW below 1");   end
      if (VL_W < 1)     begin : g_bad_vlw    $error("vload_seq: VL_W below 1");     end
      if (NUM_ENT < 1)  begin : g_bad_nent   $error("vload_seq: NUM_ENT below 1");  end
   endgenerate

   localparam int IDX_W = VL_W;

   logic [IDX_W-1:0]  idx;
   logic              load, cap_addr, cap_data, wb_en;
   logic [XLEN-1:0]   off_sel, stride_sel, addr_nx;
   logic [REG_AW-1:0] dst_q, base_q;
   logic [XLEN-1:0]   off_q, stride_q, addr_q, data_q;
   logic [REG_AW-1:0] idx_r;

   vls_ctrl #(.VL_W(VL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .vec_len   (vec_len),
      .req_ready (mem_req_ready),
      .rsp_valid (mem_rsp_valid),
      .idx       (idx),
      .load      (load),
      .cap_addr  (cap_addr),
      .cap_data  (cap_data),
      .req_valid (mem_req_valid),
      .wb_en     (wb_en),
      .busy      (busy),
      .done      (done)
   );

   vls_csr_match #(.XLEN(XLEN), .REG_AW(REG_AW), .NUM_ENT(NUM_ENT)) u_match (
      .key        (base_reg),
      .imm        (imm_off),
      .ent_reg    (ent_reg),
      .ent_off    (ent_off),
      .ent_mode   (ent_mode),
      .off_sel    (off_sel),
      .stride_sel (stride_sel)
   );

   vls_addr_calc #(.XLEN(XLEN), .IDX_W(IDX_W)) u_addr (
      .off      (off_q),
      .idx      (idx),
      .base_val (rf_rdata),
      .stride   (stride_q),
      .addr     (addr_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q    <= '0;
         base_q   <= '0;
         off_q    <= '0;
         stride_q <= XLEN'(1);
      end else if (load) begin
         dst_q    <= dst_reg;
         base_q   <= base_reg;
         off_q    <= off_sel;
         stride_q <= stride_sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (cap_addr) addr_q <= addr_nx;
         if (cap_data) data_q <= mem_rsp_data;
      end
   end

   assign idx_r        = REG_AW'(idx);
   assign rf_raddr     = base_q + idx_r;
   assign mem_req_addr = addr_q;
   assign rf_we        = wb_en;
   assign rf_waddr     = dst_q + idx_r;
   assign rf_wdata     = data_q;

endmodule

// File: rtl/vls_chk.sv
`timescale 1ns/1ps
module vls_chk #(
   parameter int XLEN    = 32,
   parameter int REG_AW  = 5,
   parameter int VL_W    = 6,
   parameter int NUM_ENT = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic [REG_AW-1:0]         dst_reg,
   input logic [REG_AW-1:0]         base_reg,
   input logic [XLEN-1:0]           imm_off,
   input logic [VL_W-1:0]           vec_len,
   input logic [NUM_ENT*REG_AW-1:0] ent_reg,
   input logic [NUM_ENT*XLEN-1:0]   ent_off,
   input logic [NUM_ENT-1:0]        ent_mode,
   input logic                      busy,
   input logic                      done,
   input logic [REG_AW-1:0]         rf_raddr,
   input logic [XLEN-1:0]           rf_rdata,
   input logic                      mem_req_valid,
   input logic                      mem_req_ready,
   input logic [XLEN-1:0]           mem_req_addr,
   input logic                      mem_rsp_valid,
   input logic [XLEN-1:0]           mem_rsp_data,
   input logic                      rf_we,
   input logic [REG_AW-1:0]         rf_waddr,
   input logic [XLEN-1:0]           rf_wdata
);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req_valid && !rf_we && !done));

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R7
   single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   // R7
   no_req_during_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> !mem_req_valid);

   // R8
   empty_vec_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && vec_len == '0) |=> (done && !mem_req_valid));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R10
   wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

endmodule

bind vload_seq vls_chk #(
   .XLEN(XLEN), .REG_AW(REG_AW), .VL_W(VL_W), .NUM_ENT(NUM_ENT)
) u_chk (.*);

// File: tb/sim_vload_seq.sv
`timescale 1ns/1ps
module sim_vload_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  dst_reg = '0, base_reg = '0;
   logic [31:0] imm_off = '0;
   logic [5:0]  vec_len = '0;
   logic [9:0]  ent_reg = '0;
   logic [63:0] ent_off = '0;
   logic [1:0]  ent_mode = '0;
   logic        busy, done;
   logic [4:0]  rf_raddr;
   logic [31:0] rf_rdata;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rf_we;
   logic [4:0]  rf_waddr;
   logic [31:0] rf_wdata;

   always #2.5 clk = ~clk;

   vload_seq u0 (.*);

   logic [31:0] regs [32];
   assign rf_rdata = regs[rf_raddr];
   always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

   int tests = 0, fails = 0;
   int unsigned cyc = 0, wd = 0;

   // reference state
   logic [31:0] q_a[$], q_wd[$];
   logic [4:0]  q_wa[$];
   bit    mon_en = 0, mb = 0, done_next = 0, m_done_due = 0, mb_now;
   bit    req_start = 0;
   int    st_vl = 0, lat = 1, rp = 0, rsp_cnt = 0;
   logic [31:0] rsp_d;
   string cur_tag = "R1";

   function automatic logic [31:0] mem_f(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'hC3A5_9E17;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 60000) begin
         fails++;
         $display("FAIL R10 watchdog: actual %0d expected below 60000", wd);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (mon_en) begin
         cyc++;
         m_done_due = done_next;
         done_next  = 0;
         chk(done === m_done_due, {"R10 ", cur_tag}, "done", 32'(done), 32'(m_done_due));
         chk(busy === mb, "R9", "busy", 32'(busy), 32'(mb));
         if (!mb) chk(!mem_req_valid && !rf_we, "R1", "idle outputs",
                      {mem_req_valid, rf_we}, 32'd0);
         if (rf_we) begin
            if (q_wa.size() == 0) begin
               chk(0, "R2", "unexpected writeback", 32'(rf_waddr), 32'd0);
            end else begin
               chk(rf_waddr == q_wa[0], "R2", "write index", 32'(rf_waddr), 32'(q_wa[0]));
               chk(rf_wdata == q_wd[0], "R11", "write data", rf_wdata, q_wd[0]);
               void'(q_wa.pop_front());
               void'(q_wd.pop_front());
               if (q_wa.size() == 0) done_next = 1;
            end
         end
         mb_now = mb;
         if (m_done_due) mb = 0;
         mem_rsp_valid = 1'b0;
         if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = rsp_d;
            end
         end
         start = 1'b0;
         if (req_start) begin
            start     = 1'b1;
            req_start = 0;
            if (!mb_now) begin
               mb = 1;
               if (st_vl == 0) done_next = 1;
            end
         end
         mem_req_ready = (rp == 0) || ((cyc % (rp + 1)) == 0);
         if (mem_req_valid && mem_req_ready) begin
            chk(rsp_cnt == 0 && !mem_rsp_valid, "R7", "request while outstanding",
                32'(rsp_cnt), 32'd0);
            if (q_a.size() == 0) begin
               chk(0, {"R8 ", cur_tag}, "unexpected request", mem_req_addr, 32'd0);
            end else begin
               chk(mem_req_addr == q_a[0], cur_tag, "address", mem_req_addr, q_a[0]);
               void'(q_a.pop_front());
            end
            rsp_cnt = lat;
            rsp_d   = mem_f(mem_req_addr);
         end
      end
   end

   task automatic run_op(input logic [4:0] d, input logic [4:0] m, input logic [31:0] imm,
                         input int vl, input logic [4:0] r0, input logic [31:0] o0,
                         input bit md0, input logic [4:0] r1, input logic [31:0] o1,
                         input bit md1, input int l, input int p, input string tag,
                         input bit poke_busy);
      logic [31:0] off, str, a;
      @(posedge clk); #1;
      dst_reg = d; base_reg = m; imm_off = imm; vec_len = 6'(vl);
      ent_reg = {r1, r0}; ent_off = {o1, o0}; ent_mode = {md1, md0};
      lat = l; rp = p; cur_tag = tag; st_vl = vl;
      off = 32'd0; str = 32'd1;
      if (r0 == m) begin off = o0; str = md0 ? imm : 32'd1; end
      else if (r1 == m) begin off = o1; str = md1 ? imm : 32'd1; end
      for (int i = 0; i < vl; i++) begin
         a = (off * 32'(i) + regs[5'(m + 5'(i))]) * str;
         q_a.push_back(a);
         q_wa.push_back(5'(d + 5'(i)));
         q_wd.push_back(mem_f(a));
      end
      req_start = 1;
      while (req_start) begin @(posedge clk); #1; end
      if (poke_busy) begin
         repeat (3) begin @(posedge clk); #1; end
         // R9: different operands while busy must not disturb the running load
         dst_reg = 5'd3; base_reg = r0; vec_len = 6'd1; st_vl = 1;
         req_start = 1;
         while (req_start) begin @(posedge clk); #1; end
      end
      while (mb || done_next) begin @(posedge clk); #1; end
      repeat (3) begin @(posedge clk); #1; end
      chk(q_a.size() == 0 && q_wa.size() == 0, {"R2 ", tag}, "leftover elements",
          32'(q_a.size() + q_wa.size()), 32'd0);
   endtask

   initial begin
      for (int k = 0; k < 32; k++) regs[k] = 32'h0001_0000 + 32'(k) * 32'h34;
      repeat (4) @(posedge clk);
      #1;
      chk(!busy && !done && !mem_req_valid && !rf_we, "R1", "reset outputs",
          {busy, done, mem_req_valid, rf_we}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      mon_en = 1;
      // R3: no entry names the base register
      run_op(5'd16, 5'd2, 32'd8, 4, 5'd9, 32'd100, 1'b1, 5'd10, 32'd7, 1'b1, 1, 0, "R3", 0);
      // R4: entry 0 matches, stride 1
      run_op(5'd20, 5'd4, 32'd12, 5, 5'd4, 32'd16, 1'b0, 5'd1, 32'd3, 1'b0, 2, 1, "R4", 0);
      // R5: only entry 1 matches, stride from immediate
      run_op(5'd24, 5'd6, 32'd4, 3, 5'd0, 32'd9, 1'b0, 5'd6, 32'd40, 1'b1, 3, 2, "R5", 0);
      // R4: both match, lower entry must win
      run_op(5'd16, 5'd4, 32'd5, 4, 5'd4, 32'd64, 1'b0, 5'd4, 32'd1000, 1'b1, 1, 0, "R4", 0);
      // R5: entry 0 in immediate-stride mode
      run_op(5'd26, 5'd1, 32'd3, 2, 5'd1, 32'd20, 1'b1, 5'd8, 32'd2, 1'b0, 1, 3, "R5", 0);
      // R8: zero length
      run_op(5'd10, 5'd4, 32'd5, 0, 5'd4, 32'd64, 1'b1, 5'd4, 32'd1, 1'b1, 1, 0, "R8", 0);
      // R6: wrapping arithmetic and register indices wrapping past 31
      @(posedge clk); #1;
      regs[30] = 32'hFFFF_FFF0; regs[31] = 32'h8000_0001; regs[0] = 32'h7FFF_FFFF;
      run_op(5'd12, 5'd30, 32'h9000_0003, 3, 5'd30, 32'hF000_0000, 1'b1, 5'd2, 32'd0,
             1'b0, 2, 1, "R6", 0);
      // R2: destination index wraps past 31
      run_op(5'd30, 5'd8, 32'd1, 4, 5'd5, 32'd0, 1'b0, 5'd7, 32'd0, 1'b0, 1, 0, "R2", 0);
      // R9: start while busy is ignored; R7 under backpressure and latency
      run_op(5'd20, 5'd8, 32'd2, 6, 5'd8, 32'd4, 1'b0, 5'd3, 32'd0, 1'b0, 4, 2, "R9", 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule